// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is a hardware master for the Ethernet PHY management channel. It divides the system clock down to a management clock (MDC) and runs complete read or write frames on the shared MDIO line, which is modelled as three separate pad signals: output, output enable and input. A host supplies a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. It then pulses `start`. The block holds `busy` for the whole frame. It ends the frame with a single-cycle `done` pulse, and `err` is valid in that same cycle.

On a read, the master releases the line after the address fields. It then checks that the PHY pulls the turnaround bit low before it accepts any data. If no PHY answers, the line stays high. In that case the master abandons the frame, clocks 32 idle cycles with the line released so that every PHY on the bus returns to a known state, and reports an error. The previous read data is left untouched.

Top module: `mdio_master`

## Requirements
- R1: After reset `mdc`, `mdio_oe`, `busy`, `done` and `err` are 0 and `rdata` is 0.
- R2: While busy, each MDC half-period lasts exactly `div_half` system cycles, and a `div_half` of 0 acts as 1. MDC is low while idle.
- R3: Every frame begins with 46 driven bits, sent most significant first: 32 ones, then 0,1, then the opcode (1,0 for a read when `rd`=1; 0,1 for a write), then `phy_adr[4:0]`, then `reg_adr[4:0]`. `mdio_o` changes only while MDC is low, so each bit is stable at the MDC rising edge.
- R4: A write continues with the driven bits 1,0 and then `wdata[15:0]`, most significant first. It then gives one more MDC cycle with `mdio_oe`=0, for 65 MDC cycles in total, and ends with `err`=0.
- R5: A read releases MDIO from MDC cycle 47 (1-based) onward and samples the turnaround on that cycle's rising edge. If the sample is 0, it captures 16 data bits most significant first on the rising edges of cycles 48 to 63. It adds one trailing cycle, for 64 cycles in total, and then presents the word on `rdata` with `err`=0.
- R6: If the sampled read turnaround is 1, the frame runs 32 further MDC cycles with MDIO released, for 79 cycles in total. It ends with `err`=1, and `rdata` keeps its previous value.
- R7: `done` is high for exactly one system cycle, `busy` is low in that cycle, and `err` keeps its value until the next accepted start.
- R8: A `start` pulse while `busy` is high is ignored: the running frame's bits and length do not change.
- R9: `mdio_oe` is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| rd | input | 1 | 1 = read frame, 0 = write frame |
| phy_adr | input | 5 | PHY address |
| reg_adr | input | 5 | Register address |
| wdata | input | 16 | Data for write frames |
| div_half | input | DIV_W | System cycles per MDC half-period |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Read turnaround failure, valid with done |
| rdata | output | 16 | Last successfully read word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach from the ports is the turnaround failure path. It needs a line that floats high exactly where a PHY should pull it low, and it needs earlier read data in place so that the bench can show that this data survives. The bench's PHY model answers reads only when enabled. It first completes a good read with a known word and then repeats the read with the model silent, so that the pull-up value reaches the turnaround sample. The model counts MDC rising edges to measure the 79-cycle flush and records every driven bit to confirm that nothing is driven during it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADR_W     = 5;
  localparam int REG_W     = 16;
  localparam int PRE_LEN   = 32;
  localparam int FLUSH_LEN = 32;
  // preamble + start(2) + opcode(2) + two address fields
  localparam int HDR_LEN   = PRE_LEN + 4 + 2 * ADR_W;
  localparam int WR_LEN    = HDR_LEN + 2 + REG_W + 1;
  localparam int RD_LEN    = HDR_LEN + 1 + REG_W + 1;
  localparam int ERR_LEN   = HDR_LEN + 1 + FLUSH_LEN;
  localparam int SR_W      = HDR_LEN + 2 + REG_W;
  localparam int CYC_W     = $clog2(ERR_LEN + 1);

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = (div_half == '0) ? DIV_W'(1) : div_half;
    tick = run && (cnt == lim - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < lim));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd,
  input  logic [ADR_W-1:0] phy_adr,
  input  logic [ADR_W-1:0] reg_adr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tick,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [REG_W-1:0] rdata
);
  localparam logic [CYC_W-1:0] C_TA   = CYC_W'(HDR_LEN);
  localparam logic [CYC_W-1:0] C_DEND = CYC_W'(HDR_LEN + REG_W);
  localparam logic [CYC_W-1:0] C_WOE  = CYC_W'(WR_LEN - 1);
  localparam logic [CYC_W-1:0] C_WL   = CYC_W'(WR_LEN - 1);
  localparam logic [CYC_W-1:0] C_RL   = CYC_W'(RD_LEN - 1);
  localparam logic [CYC_W-1:0] C_EL   = CYC_W'(ERR_LEN - 1);

  logic [SR_W-1:0]  sr;
  logic [CYC_W-1:0] cyc, cyc_nxt, cyc_last;
  logic [REG_W-1:0] rx;
  logic             rd_q, ta_bad;
  mdio_opc_e        opc;

  always_comb begin
    opc      = rd ? OPC_READ : OPC_WRITE;
    cyc_nxt  = cyc + CYC_W'(1);
    cyc_last = rd_q ? (ta_bad ? C_EL : C_RL) : C_WL;
    mdio_o   = sr[SR_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; cyc <= '0; rx <= '0; rd_q <= 1'b0; ta_bad <= 1'b0;
      mdc <= 1'b0; mdio_oe <= 1'b0; busy <= 1'b0; done <= 1'b0;
      err <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          err     <= 1'b0;
          rd_q    <= rd;
          ta_bad  <= 1'b0;
          cyc     <= '0;
          mdc     <= 1'b0;
          mdio_oe <= 1'b1;
          sr <= {{PRE_LEN{1'b1}}, 2'b01, opc, phy_adr, reg_adr, 2'b10, wdata};
        end
      end else if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_q && cyc == C_TA && mdio_i) ta_bad <= 1'b1;
          if (rd_q && cyc > C_TA && cyc <= C_DEND) rx <= {rx[REG_W-2:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (cyc == cyc_last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            err     <= ta_bad;
            if (rd_q && !ta_bad) rdata <= rx;
          end else begin
            cyc     <= cyc_nxt;
            sr      <= sr << 1;
            mdio_oe <= rd_q ? (cyc_nxt < C_TA) : (cyc_nxt < C_WOE);
          end
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9
  idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  // R3
  drive_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);
  // R2
  mdc_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc) |-> $past(tick));
  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd,
  input  logic [4:0]       phy_adr,
  input  logic [4:0]       reg_adr,
  input  logic [15:0]      wdata,
  input  logic [DIV_W-1:0] div_half,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [15:0]      rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic tick;

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div_half(div_half), .tick(tick)
  );

  mdio_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .rd(rd),
    .phy_adr(phy_adr), .reg_adr(reg_adr), .wdata(wdata),
    .tick(tick), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(busy), .done(done), .err(err), .rdata(rdata)
  );
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_P = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rd = 1'b0;
  logic [4:0] phy_adr = '0, reg_adr = '0;
  logic [15:0] wdata = '0;
  logic [DIV_W-1:0] div_half = 8'd1;
  logic busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic mdio_i = 1'b1;

  int errors = 0, checks = 0;
  int rise_cnt = 0, drv_cnt = 0, base = 0;
  logic [63:0] cap = '0;
  time last_t = 0, per = 0;
  logic phy_en = 1'b0;
  logic [15:0] phy_data = '0;
  longint cyc_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  mdio_master #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .start(start), .rd(rd), .phy_adr(phy_adr),
    .reg_adr(reg_adr), .wdata(wdata), .div_half(div_half), .busy(busy),
    .done(done), .err(err), .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: records driven bits, answers reads when enabled
  always @(posedge mdc) begin
    if (mdio_oe) begin cap = {cap[62:0], mdio_o}; drv_cnt++; end
    rise_cnt++;
    per = $time - last_t;
    last_t = $time;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_cnt - base;
    if (phy_en && k == 46) mdio_i = 1'b0;
    else if (phy_en && k >= 47 && k <= 62) mdio_i = phy_data[62-k];
    else mdio_i = 1'b1;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [45:0] hdr(input logic r, input logic [4:0] p, input logic [4:0] g);
    return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g};
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // runs one frame; returns edges, driven bits
  task automatic run_frame(input logic r, input logic [4:0] p, input logic [4:0] g,
                           input logic [15:0] w, output int edges, output int drv);
    int d0;
    rd = r; phy_adr = p; reg_adr = g; wdata = w;
    base = rise_cnt; d0 = drv_cnt;
    pulse_start();
    for (int i = 0; i < 4000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R7 done seen", done, 1);
    chk("R7 busy low with done", busy, 0);
    edges = rise_cnt - base;
    drv = drv_cnt - d0;
    @(negedge clk);
    chk("R7 done single cycle", done, 0);
    chk("R9 oe idle", mdio_oe, 0);
    chk("R2 mdc idle low", mdc, 0);
  endtask

  task automatic t_reset();
    chk("R1 mdc", mdc, 0);
    chk("R1 oe", mdio_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_write(input logic [4:0] p, input logic [4:0] g, input logic [15:0] w,
                         input logic [7:0] dv);
    int e, d;
    div_half = dv;
    run_frame(1'b0, p, g, w, e, d);
    chk("R4 write length", e, 65);
    chk("R4 driven count", d, 64);
    chk("R3 R4 write bits", cap, {hdr(1'b0, p, g), 2'b10, w});
    chk("R4 err clear", err, 0);
    chk("R2 mdc period", per, 2 * ((dv == 0) ? 1 : dv) * CLK_P);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] g, input logic [15:0] v);
    int e, d;
    phy_en = 1'b1; phy_data = v;
    run_frame(1'b1, p, g, 16'h0, e, d);
    phy_en = 1'b0;
    chk("R5 read length", e, 64);
    chk("R5 driven count", d, 46);
    chk("R3 read header", cap[45:0], hdr(1'b1, p, g));
    chk("R5 rdata", rdata, v);
    chk("R5 err clear", err, 0);
  endtask

  task automatic t_ta_fail(input logic [15:0] prev);
    int e, d;
    phy_en = 1'b0;
    run_frame(1'b1, 5'h07, 5'h11, 16'h0, e, d);
    chk("R6 flush length", e, 79);
    chk("R6 driven count", d, 46);
    chk("R6 err set", err, 1);
    chk("R6 rdata kept", rdata, prev);
    repeat (5) @(negedge clk);
    chk("R7 err held", err, 1);
  endtask

  task automatic t_busy_start();
    int d0, b0;
    div_half = 8'd2;
    rd = 1'b0; phy_adr = 5'h0A; reg_adr = 5'h15; wdata = 16'h5AA5;
    base = rise_cnt; b0 = rise_cnt; d0 = drv_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    rd = 1'b1; phy_adr = 5'h1F; reg_adr = 5'h00; wdata = 16'hFFFF;
    pulse_start();
    for (int i = 0; i < 4000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R8 done", done, 1);
    chk("R8 length unchanged", rise_cnt - b0, 65);
    chk("R8 driven count", drv_cnt - d0, 64);
    chk("R8 bits unchanged", cap, {hdr(1'b0, 5'h0A, 5'h15), 2'b10, 16'h5AA5});
    @(negedge clk);
    chk("R8 no second frame", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(5'h01, 5'h02, 16'hA5C3, 8'd1);
    t_write(5'h1E, 5'h0B, 16'h8001, 8'd3);
    t_write(5'h10, 5'h1F, 16'h7FFE, 8'd0);
    div_half = 8'd2;
    t_read(5'h03, 5'h04, 16'hBEEF);
    t_read(5'h1C, 5'h01, 16'h0001);
    t_ta_fail(16'h0001);
    t_read(5'h05, 5'h06, 16'h8000);
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule